// File: doc/BRIEF.md
# Multi-Mode Register Shifter

This block moves a WIDTH-bit register value by exactly one bit position and registers the outcome. A 3-bit operation code picks one of six shift kinds:

- logical left or right, which inserts a zero at the vacated end;
- circular left or right, which wraps the departing bit into the vacated end;
- arithmetic left or right, which treats the word as a two's-complement number.

Arithmetic right shift keeps the sign bit and copies it downward, so the value is halved. Arithmetic left shift doubles the value. It raises an overflow flag when the sign of the result would no longer match the sign of the operand.

Alongside the shifted word, the block returns a carry bit that holds the bit pushed out of the word. Every rising clock edge captures the current operand and operation code. The result, carry and overflow for those inputs appear on the outputs one cycle later. An asynchronous active-low reset clears all three outputs. WIDTH is normally 8 or 16.

Top module: `reg_shifter`

## Requirements
- R1: While rst_n is low, shift_out, carry_out and ovf_out are all 0.
- R2: The outputs change only at a rising clock edge and reflect the op_sel and operand sampled at that edge; between edges they hold.
- R3: op_sel 000 (logical left) gives {operand[W-2:0],0}, and op_sel 001 (logical right) gives {0,operand[W-1:1]}.
- R4: op_sel 010 (circular left) gives {operand[W-2:0],operand[W-1]}, and op_sel 011 (circular right) gives {operand[0],operand[W-1:1]}. No bit is lost.
- R5: op_sel 101 (arithmetic right) gives {operand[W-1],operand[W-1:1]}. Bit W-1 is unchanged, and a negative value fills 1s from the top.
- R6: op_sel 100 (arithmetic left) produces the same word as logical left, with 0 entering bit 0.
- R7: For op_sel 100, ovf_out is operand[W-1] XOR operand[W-2].
- R8: For every op_sel other than 100, ovf_out is 0.
- R9: For the six shift codes, carry_out is operand[W-1] for left shifts (000, 010, 100) and operand[0] for right shifts (001, 011, 101).
- R10: op_sel 110 and 111 pass the operand through unchanged, with carry_out and ovf_out both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code |
| operand | input | WIDTH | Word to be shifted |
| shift_out | output | WIDTH | Registered shifted word |
| carry_out | output | 1 | Registered bit shifted out of the word |
| ovf_out | output | 1 | Registered overflow flag of arithmetic left shift |

## Verification
The hardest case to reach is one that separates arithmetic left shift from logical left shift. The two produce identical words, so only the overflow flag tells them apart. The stimulus therefore feeds operands whose two top bits differ, such as 0x4001 and 0x8000, to both codes: overflow must rise only for the arithmetic one. Arithmetic right shift is driven with both positive and negative all-ones patterns to show the sign copy. The pass-through codes are given operands whose end bits are 1, so a carry leaking from the shift paths would show up.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    // Operation codes seen on op_sel
    localparam logic [2:0] OP_SHL  = 3'b000;
    localparam logic [2:0] OP_SHR  = 3'b001;
    localparam logic [2:0] OP_CIL  = 3'b010;
    localparam logic [2:0] OP_CIR  = 3'b011;
    localparam logic [2:0] OP_ASHL = 3'b100;
    localparam logic [2:0] OP_ASHR = 3'b101;

    // What enters the vacated end position
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_WRAP = 2'd1,
        FILL_SIGN = 2'd2
    } fill_e;

endpackage

// File: rtl/shift_step.sv
module shift_step
    import shifter_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit TO_LEFT = 1'b1
) (
    input  logic [WIDTH-1:0] word_i,
    input  fill_e            fill_i,
    output logic [WIDTH-1:0] word_o,
    output logic             lost_bit_o
);

    logic fill_bit;

    generate
        if (TO_LEFT) begin : g_left
            // Sign fill has no meaning toward the left; it inserts zero
            always_comb begin
                fill_bit   = (fill_i == FILL_WRAP) ? word_i[WIDTH-1] : 1'b0;
                word_o     = {word_i[WIDTH-2:0], fill_bit};
                lost_bit_o = word_i[WIDTH-1];
            end
        end else begin : g_right
            always_comb begin
                unique case (fill_i)
                    FILL_WRAP: fill_bit = word_i[0];
                    FILL_SIGN: fill_bit = word_i[WIDTH-1];
                    default:   fill_bit = 1'b0;
                endcase
                word_o     = {fill_bit, word_i[WIDTH-1:1]};
                lost_bit_o = word_i[0];
            end
        end
    endgenerate

endmodule

// File: rtl/reg_shifter.sv
module reg_shifter
    import shifter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] shift_out,
    output logic             carry_out,
    output logic             ovf_out
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             carry;
        logic             ovf;
    } shift_state_t;

    shift_state_t state_d, state_q;

    fill_e            left_fill, right_fill;
    logic [WIDTH-1:0] left_word, right_word;
    logic             left_lost, right_lost;

    always_comb begin
        left_fill  = (op_sel == OP_CIL) ? FILL_WRAP : FILL_ZERO;
        if (op_sel == OP_CIR)       right_fill = FILL_WRAP;
        else if (op_sel == OP_ASHR) right_fill = FILL_SIGN;
        else                        right_fill = FILL_ZERO;
    end

    shift_step #(.WIDTH(WIDTH), .TO_LEFT(1'b1)) i_left (
        .word_i     (operand),
        .fill_i     (left_fill),
        .word_o     (left_word),
        .lost_bit_o (left_lost)
    );

    shift_step #(.WIDTH(WIDTH), .TO_LEFT(1'b0)) i_right (
        .word_i     (operand),
        .fill_i     (right_fill),
        .word_o     (right_word),
        .lost_bit_o (right_lost)
    );

    always_comb begin
        state_d = '{word: operand, carry: 1'b0, ovf: 1'b0};
        unique case (op_sel)
            OP_SHL, OP_CIL, OP_ASHL: begin
                state_d.word  = left_word;
                state_d.carry = left_lost;
                state_d.ovf   = (op_sel == OP_ASHL) && (operand[MSB] != operand[MSB-1]);
            end
            OP_SHR, OP_CIR, OP_ASHR: begin
                state_d.word  = right_word;
                state_d.carry = right_lost;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign shift_out = state_q.word;
    assign carry_out = state_q.carry;
    assign ovf_out   = state_q.ovf;

    // Marks that the registered outputs stem from inputs sampled out of reset
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (shift_out == '0 && !carry_out && !ovf_out)); // R1

    AST_OVF_ASHL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ovf_out) |-> ($past(op_sel) == OP_ASHL)); // R8

    AST_OVF_SIGN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_sel) == OP_ASHL) |-> (ovf_out == (shift_out[MSB] != $past(operand[MSB])))); // R7

    AST_ASHR_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_sel) == OP_ASHR) |-> (shift_out[MSB] == $past(operand[MSB]) && shift_out[MSB-1] == $past(operand[MSB]))); // R5

    AST_CIRC_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_sel) == OP_CIL || $past(op_sel) == OP_CIR)) |-> ($countones(shift_out) == $countones($past(operand)))); // R4

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_sel) == OP_SHL || $past(op_sel) == OP_ASHL)) |-> !shift_out[0]); // R6

    AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_sel) == OP_SHL || $past(op_sel) == OP_CIL || $past(op_sel) == OP_ASHL)) |-> (carry_out == $past(operand[MSB]))); // R9

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_sel[2:1]) == 2'b11) |-> (shift_out == $past(operand) && !carry_out && !ovf_out)); // R10

endmodule

// File: tb/test_reg_shifter.sv
`timescale 1ns/1ps
module test_reg_shifter;

    localparam int W  = 16;
    localparam int NV = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic [W-1:0] operand = '0;
    logic [W-1:0] shift_out;
    logic         carry_out;
    logic         ovf_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    reg_shifter #(.WIDTH(W)) i_reg_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .operand   (operand),
        .shift_out (shift_out),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] din;
        logic [W-1:0] res;
        logic         cy;
        logic         ov;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        {3'b000, 16'h8001, 16'h0002, 1'b1, 1'b0},  // R3 R9
        {3'b001, 16'h8001, 16'h4000, 1'b1, 1'b0},  // R3 R9
        {3'b010, 16'h8001, 16'h0003, 1'b1, 1'b0},  // R4
        {3'b011, 16'h8001, 16'hC000, 1'b1, 1'b0},  // R4
        {3'b101, 16'h8004, 16'hC002, 1'b0, 1'b0},  // R5
        {3'b101, 16'h7FFF, 16'h3FFF, 1'b1, 1'b0},  // R5
        {3'b100, 16'h4001, 16'h8002, 1'b0, 1'b1},  // R6 R7
        {3'b100, 16'hC000, 16'h8000, 1'b1, 1'b0},  // R7
        {3'b100, 16'h8000, 16'h0000, 1'b1, 1'b1},  // R7
        {3'b100, 16'h1234, 16'h2468, 1'b0, 1'b0},  // R6
        {3'b000, 16'h4001, 16'h8002, 1'b0, 1'b0},  // R8
        {3'b001, 16'hFFFE, 16'h7FFF, 1'b0, 1'b0},  // R3
        {3'b011, 16'h0001, 16'h8000, 1'b1, 1'b0},  // R4
        {3'b010, 16'hA5A5, 16'h4B4B, 1'b1, 1'b0},  // R4
        {3'b110, 16'h4001, 16'h4001, 1'b0, 1'b0},  // R10
        {3'b111, 16'h8001, 16'h8001, 1'b0, 1'b0},  // R10
        {3'b101, 16'h0000, 16'h0000, 1'b0, 1'b0},  // R5
        {3'b101, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0}   // R5
    };

    function automatic string word_tag(logic [2:0] op);
        case (op)
            3'b000, 3'b001: return "R3";
            3'b010, 3'b011: return "R4";
            3'b100:         return "R6";
            3'b101:         return "R5";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] op, logic [W-1:0] din);
        @(negedge clk);
        op_sel  = op;
        operand = din;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("[TB] FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset holds outputs at zero even with a live operand
        op_sel  = 3'b010;
        operand = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1", {16'h0, shift_out}, 32'h0);
        check("R1", {30'h0, carry_out, ovf_out}, 32'h0);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].op, VECS[k].din);
            check(word_tag(VECS[k].op), {16'h0, shift_out}, {16'h0, VECS[k].res});
            check((VECS[k].op[2:1] == 2'b11) ? "R10" : "R9",
                  {31'h0, carry_out}, {31'h0, VECS[k].cy});
            check((VECS[k].op == 3'b100) ? "R7" : ((VECS[k].op[2:1] == 2'b11) ? "R10" : "R8"),
                  {31'h0, ovf_out}, {31'h0, VECS[k].ov});
        end

        // R2: a new input does not reach the outputs before the next rising edge
        apply(3'b000, 16'h0001);
        check("R2", {16'h0, shift_out}, 32'h0002);
        @(negedge clk);
        op_sel  = 3'b001;
        operand = 16'h8000;
        #1;
        check("R2", {16'h0, shift_out}, 32'h0002);
        @(negedge clk);
        check("R2", {16'h0, shift_out}, 32'h4000);

        // R8: logical left with differing top bits raises no overflow
        apply(3'b000, 16'hBFFF);
        check("R8", {31'h0, ovf_out}, 32'h0);
        check("R3", {16'h0, shift_out}, 32'h7FFE);

        // R7: overflow clears on the following non-overflowing arithmetic left
        apply(3'b100, 16'h8000);
        check("R7", {31'h0, ovf_out}, 32'h1);
        apply(3'b100, 16'hFFFF);
        check("R7", {31'h0, ovf_out}, 32'h0);
        check("R6", {16'h0, shift_out}, 32'hFFFE);

        // R1: reset asserted mid-run clears the held outputs
        apply(3'b011, 16'h0001);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", {16'h0, shift_out}, 32'h0);
        check("R1", {31'h0, carry_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(3'b101, 16'hF000);
        check("R5", {16'h0, shift_out}, 32'hF800);

        finish_run();
    end

endmodule